// File: doc/BRIEF.md
# Keyhole Readback Packet FIFO

This block buffers configuration readback data on its way from an internal frame interface to a bus master. On the ingress side a producer presents a fixed-size packet of 32-bit words in a single cycle with a valid strobe. The block has no backpressure. It admits the packet as a whole only when the queue has room for every word of it. If there is not enough room, it throws the whole packet away and raises a drop flag.

On the bus side the block is one keyhole window of 4 KiB. The address decoder upstream raises `bus_req_i` for any offset inside the window, and the offset itself plays no part. Every full-width read takes the oldest word out of the queue. A read of an empty queue returns zero. Writes and accesses narrower than 4 bytes are refused and flagged. Read data is little-endian, so byte 0 sits in bits 7:0. A reset empties the queue.

Top module: `kh_readback_fifo`

## Requirements
- R1: A bus request with `bus_we_i`=0 and `bus_be_i`=4'b1111 on a non-empty queue removes the oldest word. In the next cycle that word appears on `bus_rdata_o` with `bus_ack_o`=1.
- R2: Such a read on an empty queue returns 0 on `bus_rdata_o`, still acknowledges, and leaves occupancy unchanged.
- R3: A bus request with `bus_we_i`=1 is acknowledged in the next cycle with `bus_rdata_o`=0 and a one-cycle pulse on `err_access_o`. Occupancy and queued contents are unchanged.
- R4: A read with `bus_be_i` other than 4'b1111 is refused in the same way as a write: ack, data 0, `err_access_o` pulse, and no pop.
- R5: A packet is admitted when `free_cnt_o` is at least PKT_WORDS (4) at the clock edge. Word i is taken from bits [32i+31:32i] of `pkt_data_i` and is queued in index order, word 0 first.
- R6: A packet that arrives while `free_cnt_o` < 4 is discarded entirely. No word of it is queued, and `err_drop_o` pulses for one cycle after the edge.
- R7: The queue holds DEPTH (2048) words. `free_cnt_o` equals DEPTH minus occupancy, and `empty_o` is 1 exactly when occupancy is 0.
- R8: A packet push and a bus pop in the same cycle are both applied, and occupancy changes by +4-1. Admission uses the free count from before that cycle's pop.
- R9: While `rst_ni` is low the queue is empty: `free_cnt_o`=DEPTH, `empty_o`=1, and `bus_ack_o`, `err_access_o` and `err_drop_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Packet present this cycle |
| pkt_data_i | input | 128 | Packet words, word 0 in the low 32 bits |
| bus_req_i | input | 1 | Access hitting the window (any offset) |
| bus_we_i | input | 1 | Access is a write |
| bus_be_i | input | 4 | Byte enables of the access |
| bus_ack_o | output | 1 | Access completed, one cycle after request |
| bus_rdata_o | output | 32 | Read data, valid with ack |
| err_access_o | output | 1 | One-cycle pulse for a refused access |
| err_drop_o | output | 1 | One-cycle pulse for a dropped packet |
| free_cnt_o | output | 12 | Free word entries |
| empty_o | output | 1 | Queue empty |

## Verification
The assertions check on every cycle the occupancy arithmetic for push, pop and both together. They also check the ack timing, the zero data on an empty or refused read, the error pulses caused by a write or a packet that does not fit, and the tie between `empty_o` and `free_cnt_o`. The word order through the queue, the exact fill boundary at which a packet still fits, and data integrity over a full wrap of the storage are shown only by the bench's scenarios. Those scenarios also show that a refused write leaves queued data intact and that a mid-run reset discards content. The bench compares all of this against its queue model.

// File: rtl/kh_pkg.sv
package kh_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_READ   = 2'd1,
    ACC_REJECT = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/kh_word_fifo.sv
module kh_word_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 2048,
  parameter int PW    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [PW*DW-1:0] push_data_i,
  input  logic             pop_i,
  output logic [DW-1:0]    head_o,
  output logic [CW-1:0]    count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  // storage carries no reset; occupancy alone defines validity
  always_ff @(posedge clk_i) begin
    if (push_i) begin
      for (int i = 0; i < PW; i++) begin
        mem_q[wr_ptr_q + AW'(i)] <= push_data_i[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + AW'(PW);
      if (pop_i)  rd_ptr_q <= rd_ptr_q + AW'(1);
      count_q <= count_q + (push_i ? CW'(PW) : '0) - (pop_i ? CW'(1) : '0);
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;
endmodule

// File: rtl/kh_admit.sv
module kh_admit #(
  parameter int PW  = 4,
  parameter int CW  = 12
) (
  input  logic          valid_i,
  input  logic [CW-1:0] free_i,
  output logic          accept_o,
  output logic          drop_o
);
  logic fits;
  // decision on pre-pop free space: a same-cycle pop never helps a packet in
  assign fits     = free_i >= CW'(PW);
  assign accept_o = valid_i && fits;
  assign drop_o   = valid_i && !fits;
endmodule

// File: rtl/kh_bus_port.sv
module kh_bus_port
  import kh_pkg::*;
#(
  parameter int DW  = 32,
  localparam int BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [BW-1:0] be_i,
  input  logic [DW-1:0] head_i,
  input  logic          empty_i,
  output logic          pop_o,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          err_access_o
);
  acc_kind_e kind;

  always_comb begin
    kind = ACC_IDLE;
    if (req_i) kind = (!we_i && (be_i == '1)) ? ACC_READ : ACC_REJECT;
  end

  assign pop_o = (kind == ACC_READ) && !empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o        <= 1'b0;
      rdata_o      <= '0;
      err_access_o <= 1'b0;
    end else begin
      ack_o        <= kind != ACC_IDLE;
      rdata_o      <= pop_o ? head_i : '0;
      err_access_o <= kind == ACC_REJECT;
    end
  end
endmodule

// File: rtl/kh_readback_fifo.sv
module kh_readback_fifo #(
  parameter int DW        = 32,
  parameter int DEPTH     = 2048,
  parameter int PKT_WORDS = 4,
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int BW       = DW / 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pkt_valid_i,
  input  logic [PKT_WORDS*DW-1:0] pkt_data_i,
  input  logic                    bus_req_i,
  input  logic                    bus_we_i,
  input  logic [BW-1:0]           bus_be_i,
  output logic                    bus_ack_o,
  output logic [DW-1:0]           bus_rdata_o,
  output logic                    err_access_o,
  output logic                    err_drop_o,
  output logic [CW-1:0]           free_cnt_o,
  output logic                    empty_o
);
  logic [CW-1:0] count;
  logic [DW-1:0] head;
  logic          accept, drop, pop;

  assign free_cnt_o = CW'(DEPTH) - count;
  assign empty_o    = count == '0;

  kh_admit #(.PW(PKT_WORDS), .CW(CW)) u_admit (
    .valid_i  (pkt_valid_i),
    .free_i   (free_cnt_o),
    .accept_o (accept),
    .drop_o   (drop)
  );

  kh_word_fifo #(.DW(DW), .DEPTH(DEPTH), .PW(PKT_WORDS)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (accept),
    .push_data_i (pkt_data_i),
    .pop_i       (pop),
    .head_o      (head),
    .count_o     (count)
  );

  kh_bus_port #(.DW(DW)) u_bus (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (bus_req_i),
    .we_i         (bus_we_i),
    .be_i         (bus_be_i),
    .head_i       (head),
    .empty_i      (empty_o),
    .pop_o        (pop),
    .ack_o        (bus_ack_o),
    .rdata_o      (bus_rdata_o),
    .err_access_o (err_access_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_drop_o <= 1'b0;
    else         err_drop_o <= drop;
  end
endmodule

// File: rtl/kh_readback_fifo_chk.sv
module kh_readback_fifo_chk #(
  parameter int DW        = 32,
  parameter int DEPTH     = 2048,
  parameter int PKT_WORDS = 4,
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int BW       = DW / 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pkt_valid_i,
  input logic          bus_req_i,
  input logic          bus_we_i,
  input logic [BW-1:0] bus_be_i,
  input logic          bus_ack_o,
  input logic [DW-1:0] bus_rdata_o,
  input logic          err_access_o,
  input logic          err_drop_o,
  input logic [CW-1:0] free_cnt_o,
  input logic          empty_o
);
  logic past_ok_q;
  logic rd_full, rd_pop, pkt_fits, refused;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  assign rd_full  = bus_req_i && !bus_we_i && (bus_be_i == '1);
  assign rd_pop   = rd_full && !empty_o;
  assign pkt_fits = pkt_valid_i && (int'(free_cnt_o) >= PKT_WORDS);
  assign refused  = bus_req_i && (bus_we_i || (bus_be_i != '1));

  // R7: reported free space never exceeds capacity
  a_r7_free_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(free_cnt_o) <= DEPTH);

  a_r7_empty_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o == (int'(free_cnt_o) == DEPTH));

  // R8: occupancy follows admitted packets and pops, together or alone
  a_r8_occupancy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> int'(free_cnt_o) == int'($past(free_cnt_o))
      - ($past(pkt_fits) ? PKT_WORDS : 0) + ($past(rd_pop) ? 1 : 0));

  a_r1_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i |=> bus_ack_o);

  a_r1_no_spurious_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_i |=> !bus_ack_o);

  a_r2_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_full && empty_o) |=> (bus_rdata_o == '0) && !err_access_o);

  a_r3_refused_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refused |=> err_access_o && (bus_rdata_o == '0));

  a_r4_no_flag_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refused |=> !err_access_o);

  a_r6_drop_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !pkt_fits) |=> err_drop_o);

  a_r6_no_false_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_valid_i && !pkt_fits) |=> !err_drop_o);
endmodule

bind kh_readback_fifo kh_readback_fifo_chk #(
  .DW(DW), .DEPTH(DEPTH), .PKT_WORDS(PKT_WORDS)
) u_chk (.*);

// File: tb/tb_kh_readback_fifo.sv
module tb_kh_readback_fifo;
  localparam int DEPTH = 2048;
  localparam int PW    = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         pkt_valid_i = 1'b0;
  logic [127:0] pkt_data_i = '0;
  logic         bus_req_i = 1'b0;
  logic         bus_we_i = 1'b0;
  logic [3:0]   bus_be_i = 4'hF;
  logic         bus_ack_o;
  logic [31:0]  bus_rdata_o;
  logic         err_access_o;
  logic         err_drop_o;
  logic [11:0]  free_cnt_o;
  logic         empty_o;

  kh_readback_fifo dut (.*);

  always #4 clk_i = ~clk_i;

  int unsigned model_q[$];
  int n_checks = 0;
  int n_fails  = 0;
  int seq = 0;
  bit exp_ack, exp_acc, exp_drop;
  logic [31:0] exp_rdata;
  bit finished = 1'b0;

  function automatic logic [127:0] mk_pkt(input int base);
    logic [127:0] p;
    for (int i = 0; i < PW; i++) p[i*32 +: 32] = 32'hC0DE_0000 + 32'(base * PW + i);
    return p;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "ack", 32'(bus_ack_o), 32'(exp_ack));
    chk(tag, "rdata", bus_rdata_o, exp_rdata);
    chk(tag, "err_access", 32'(err_access_o), 32'(exp_acc));
    chk(tag, "err_drop", 32'(err_drop_o), 32'(exp_drop));
    chk("R7", "free_cnt", 32'(free_cnt_o), 32'(DEPTH - model_q.size()));
    chk("R7", "empty", 32'(empty_o), 32'(model_q.size() == 0));
  endtask

  // one cycle: drive at negedge, model the edge, compare at the next negedge
  task automatic cyc(input bit pv, input logic [127:0] pd, input bit rq, input bit we,
                     input logic [3:0] be, input string tag);
    bit good_rd, fits;
    pkt_valid_i = pv; pkt_data_i = pd;
    bus_req_i = rq; bus_we_i = we; bus_be_i = be;
    good_rd   = rq && !we && be == 4'hF;
    fits      = pv && (DEPTH - model_q.size()) >= PW;
    exp_ack   = rq;
    exp_acc   = rq && !good_rd;
    exp_drop  = pv && !fits;
    exp_rdata = '0;
    if (good_rd && model_q.size() > 0) exp_rdata = model_q.pop_front();
    if (fits) for (int i = 0; i < PW; i++) model_q.push_back(pd[i*32 +: 32]);
    @(posedge clk_i);
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, '0, 1'b0, 1'b0, 4'hF, tag);
  endtask

  task automatic push(input string tag);
    cyc(1'b1, mk_pkt(seq), 1'b0, 1'b0, 4'hF, tag);
    seq++;
  endtask

  task automatic rd(input string tag);
    cyc(1'b0, '0, 1'b1, 1'b0, 4'hF, tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    pkt_valid_i = 1'b0; bus_req_i = 1'b0; bus_we_i = 1'b0; bus_be_i = 4'hF;
    model_q.delete();
    exp_ack = 0; exp_acc = 0; exp_drop = 0; exp_rdata = '0;
    @(negedge clk_i);
    compare("R9");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R9");
  endtask

  initial begin
    exp_ack = 0; exp_acc = 0; exp_drop = 0; exp_rdata = '0;
    repeat (3) @(negedge clk_i);
    compare("R9");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R9");

    rd("R2");
    idle("R2");
    push("R5");
    push("R5");
    for (int i = 0; i < 3; i++) rd("R1");
    cyc(1'b0, '0, 1'b1, 1'b1, 4'hF, "R3");
    cyc(1'b0, '0, 1'b1, 1'b1, 4'h0, "R3");
    for (int i = 0; i < 2; i++) rd("R1");
    cyc(1'b0, '0, 1'b1, 1'b0, 4'h3, "R4");
    cyc(1'b0, '0, 1'b1, 1'b0, 4'h1, "R4");
    rd("R1");
    // push and pop in one cycle
    cyc(1'b1, mk_pkt(seq), 1'b1, 1'b0, 4'hF, "R8"); seq++;
    cyc(1'b1, mk_pkt(seq), 1'b1, 1'b1, 4'hF, "R8"); seq++;
    for (int i = 0; i < 2; i++) rd("R1");

    // fill to the last packet that still fits
    while (DEPTH - model_q.size() >= PW) push("R5");
    push("R6");
    push("R6");
    // one pop frees space, but the same-cycle packet is still judged before it
    while (DEPTH - model_q.size() < PW - 1) rd("R1");
    cyc(1'b1, mk_pkt(seq), 1'b1, 1'b0, 4'hF, "R8"); seq++;
    push("R5");
    cyc(1'b0, '0, 1'b1, 1'b1, 4'hF, "R3");
    while (model_q.size() > 0) rd("R1");
    rd("R2");
    cyc(1'b1, mk_pkt(seq), 1'b1, 1'b0, 4'hF, "R8"); seq++;
    for (int i = 0; i < PW; i++) rd("R1");

    push("R9");
    push("R9");
    do_reset();
    rd("R9");
    push("R5");
    for (int i = 0; i < PW + 1; i++) rd("R1");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule